// File: doc/BRIEF.md
# Power Monitor I2C Slave Interface

This block is the serial front end of a current and voltage monitor. It is a 7-bit-address I2C fast-mode slave. Both bus lines are sampled on the system clock, cleaned up and edge-detected. SDA is driven only as a pull-low enable. The slave address comes from two strap inputs. Each strap is a 2-bit code for one of four board-level pin states. The block has no registers of its own. Writes are passed on as one-cycle strobes to the conversion sequencer's command register and to the alert block's extended registers. Reads return the sequencer's latest results or the alert status byte.

A write whose first data byte has bit 7 clear loads the command register. A write whose first data byte has bit 7 set names an extended register, and the next byte is the data for that register. The read format follows the command register: voltage, current or both channels, or the status byte. A read address is refused while a one-shot conversion that was asked for is still pending.

Top module: `pmon_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when it equals 0x60 + 8*strap_hi + 2*strap_lo, with bit 0 as the read flag (1 = read). That is, the 7-bit address is binary 011, then strap_hi, then strap_lo. Any other address byte gets no acknowledge, and the rest of that transaction is ignored.
- R2: In a write, a first data byte with bit 7 = 0 produces one cmd_we pulse, with cmd_wdata equal to the low seven bits of that byte.
- R3: In a write, a first data byte with bit 7 = 1 selects an extended register by its low two bits: 0 = alert enable, 1 = threshold, 2 = control. The second byte then produces one ext_we pulse carrying that selector and the byte. Selector 3 produces no strobe. Any further data bytes are acknowledged and have no effect.
- R4: A quick command is an address with the write flag followed directly by a stop. It is acknowledged and produces no strobe.
- R5: Voltage is enabled when cmd_cur bit 0 or bit 1 is set. Current is enabled when cmd_cur bit 2 or bit 3 is set. When both are enabled and bit 6 is clear, a read returns three bytes: voltage bits 11:4, then current bits 11:4, then voltage bits 3:0 in the high nibble with current bits 3:0 in the low nibble.
- R6: When exactly one channel is enabled and bit 6 is clear, a read returns two bytes: that channel's bits 11:4, then its bits 3:0 in the high nibble with zeros in the low nibble. With neither channel enabled, the bytes read as zero.
- R7: When cmd_cur bit 6 is set, the first byte of a read is status_byte, whatever the channel bits are.
- R8: SDA is pulled low only while SCL is low. Once the master does not acknowledge a read byte, SDA stays released until the next start.
- R9: While rd_pending is high, a read address gets no acknowledge. A write address is still acknowledged and its command takes effect.
- R10: A start or a stop in any bit position ends the current transaction and releases SDA. A write cut short this way produces no strobe.
- R11: Each bus line passes a two-stage synchronizer and then a three-sample agreement filter. A pulse on SDA lasting two system clocks while SCL is high is ignored. A pulse of six clocks is taken as a start followed by a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low |
| strap_hi | input | 2 | Address strap code for address bits 4:3 |
| strap_lo | input | 2 | Address strap code for address bits 2:1 |
| cmd_cur | input | 7 | Current command register contents from the sequencer |
| rd_pending | input | 1 | A requested one-shot result is not ready yet |
| volt_code | input | 12 | Latest voltage conversion result |
| curr_code | input | 12 | Latest current conversion result |
| status_byte | input | 8 | Alert status byte |
| cmd_we | output | 1 | One-cycle command register write strobe |
| cmd_wdata | output | 7 | Command register write data |
| ext_we | output | 1 | One-cycle extended register write strobe |
| ext_sel | output | 2 | Extended register selector |
| ext_wdata | output | 8 | Extended register write data |

## Verification
Two situations are hard to reach from the ports. The first is a read refused while a one-shot result is pending. The bench raises rd_pending between transactions and checks three things: the read address gets no acknowledge, a write in the same state still lands, and the same read is accepted once the flag drops. The second is the line filter's boundary. The bench drives SDA low for two clocks and then for six clocks inside one SCL high period of a command byte. The first pulse must leave the byte intact, and the second must abort it without a strobe. A sweep over all sixteen strap settings against every candidate address, together with every low channel-select pattern in the command, covers the decode and the reply layouts.

// File: rtl/pmon_i2c_pkg.sv
package pmon_i2c_pkg;
    localparam int unsigned CODE_W = 12;
    localparam int unsigned HI_W   = 8;
    localparam int unsigned LO_W   = CODE_W - HI_W;
    localparam int unsigned RBUF_W = 24;
    localparam logic [2:0]  ADDR_PREFIX = 3'b011;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_ACK_W, S_ACK_R, S_WDATA, S_WACK, S_RDATA, S_RACK
    } bus_st_e;

    typedef struct packed {
        bus_st_e            st;
        logic [3:0]         bits;
        logic [7:0]         sh;
        logic [RBUF_W-1:0]  rbuf;
        logic               pull;
        logic [1:0]         bidx;
        logic               ext_pend;
        logic [1:0]         esel;
        logic               nack;
        logic               cmd_we;
        logic               ext_we;
        logic [7:0]         wdata;
    } fsm_t;
endpackage

// File: rtl/pmon_i2c_filt.sv
module pmon_i2c_filt #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEPTH       = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic [DEPTH-1:0]       win_d, win_q;
    logic                   lvl_d, lvl_q, prev_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], raw};
        win_d  = {win_q[DEPTH-2:0], sync_q[SYNC_STAGES-1]};
        if (&win_q)       lvl_d = 1'b1;
        else if (~|win_q) lvl_d = 1'b0;
        else              lvl_d = lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            lvl_q  <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            win_q  <= win_d;
            lvl_q  <= lvl_d;
            prev_q <= lvl_q;
        end
    end

    assign level = lvl_q;
    assign rise  = lvl_q & ~prev_q;
    assign fall  = ~lvl_q & prev_q;
endmodule

// File: rtl/pmon_i2c_reply.sv
module pmon_i2c_reply
    import pmon_i2c_pkg::*;
(
    input  logic [1:0]        strap_hi,
    input  logic [1:0]        strap_lo,
    input  logic [6:0]        cmd,
    input  logic [CODE_W-1:0] volt,
    input  logic [CODE_W-1:0] curr,
    input  logic [7:0]        status,
    output logic [6:0]        own_addr,
    output logic [RBUF_W-1:0] reply
);
    logic v_on, i_on;
    logic unused_cmd;
    assign unused_cmd = ^cmd[5:4];

    always_comb begin
        own_addr = {ADDR_PREFIX, strap_hi, strap_lo};
        v_on = cmd[0] | cmd[1];
        i_on = cmd[2] | cmd[3];
        if (cmd[6])
            reply = {status, 16'h0000};
        else if (v_on && i_on)
            reply = {volt[CODE_W-1:LO_W], curr[CODE_W-1:LO_W], volt[LO_W-1:0], curr[LO_W-1:0]};
        else if (v_on)
            reply = {volt[CODE_W-1:LO_W], volt[LO_W-1:0], {(8-LO_W){1'b0}}, 8'h00};
        else if (i_on)
            reply = {curr[CODE_W-1:LO_W], curr[LO_W-1:0], {(8-LO_W){1'b0}}, 8'h00};
        else
            reply = '0;
    end
endmodule

// File: rtl/pmon_i2c_fsm.sv
module pmon_i2c_fsm
    import pmon_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [6:0]        own_addr,
    input  logic [RBUF_W-1:0] reply,
    input  logic              rd_pending,
    output logic              sda_pull,
    output logic              cmd_we,
    output logic [6:0]        cmd_wdata,
    output logic              ext_we,
    output logic [1:0]        ext_sel,
    output logic [7:0]        ext_wdata
);
    localparam fsm_t FSM_RESET = '0;
    fsm_t d, q;
    logic start_ev, stop_ev, match;

    always_comb begin
        d = q;
        d.cmd_we = 1'b0;
        d.ext_we = 1'b0;
        start_ev = sda_fall & scl_lvl;
        stop_ev  = sda_rise & scl_lvl;
        match    = (q.sh[7:1] == own_addr);
        if (start_ev) begin
            d.st = S_ADDR;  d.bits = '0;  d.pull = 1'b0;
            d.ext_pend = 1'b0;  d.bidx = '0;
        end else if (stop_ev) begin
            d.st = S_IDLE;  d.pull = 1'b0;  d.ext_pend = 1'b0;
        end else begin
            case (q.st)
                S_ADDR, S_WDATA: begin
                    if (scl_rise && q.bits < 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_lvl};
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        if (q.st == S_ADDR) begin
                            if (match && !(q.sh[0] && rd_pending)) begin
                                d.pull = 1'b1;
                                d.st   = q.sh[0] ? S_ACK_R : S_ACK_W;
                                d.bidx = '0;
                                d.ext_pend = 1'b0;
                                if (q.sh[0]) d.rbuf = reply;
                            end else begin
                                d.st = S_IDLE;
                            end
                        end else begin
                            if (q.bidx == 2'd0) begin
                                if (!q.sh[7]) begin
                                    d.cmd_we = 1'b1;
                                    d.wdata  = {1'b0, q.sh[6:0]};
                                end else begin
                                    d.ext_pend = 1'b1;
                                    d.esel     = q.sh[1:0];
                                end
                            end else if (q.bidx == 2'd1 && q.ext_pend) begin
                                d.ext_pend = 1'b0;
                                d.ext_we   = (q.esel != 2'b11);
                                d.wdata    = q.sh;
                            end
                            d.bidx = (q.bidx == 2'd3) ? 2'd3 : q.bidx + 2'd1;
                            d.pull = 1'b1;
                            d.st   = S_WACK;
                        end
                    end
                end
                S_ACK_W, S_WACK: begin
                    if (scl_fall) begin
                        d.pull = 1'b0;  d.st = S_WDATA;  d.bits = '0;
                    end
                end
                S_ACK_R: begin
                    if (scl_fall) begin
                        d.st = S_RDATA;  d.bits = '0;  d.pull = ~q.rbuf[RBUF_W-1];
                    end
                end
                S_RDATA: begin
                    if (scl_rise && q.bits < 4'd8) begin
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall) begin
                        d.rbuf = {q.rbuf[RBUF_W-2:0], 1'b0};
                        if (q.bits == 4'd8) begin
                            d.pull = 1'b0;  d.st = S_RACK;
                        end else begin
                            d.pull = ~q.rbuf[RBUF_W-2];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        d.nack = sda_lvl;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            d.st = S_IDLE;  d.pull = 1'b0;
                        end else begin
                            d.st = S_RDATA;  d.bits = '0;  d.pull = ~q.rbuf[RBUF_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FSM_RESET;
        else        q <= d;
    end

    assign sda_pull  = q.pull;
    assign cmd_we    = q.cmd_we;
    assign cmd_wdata = q.wdata[6:0];
    assign ext_we    = q.ext_we;
    assign ext_sel   = q.esel;
    assign ext_wdata = q.wdata;

    p_cmd_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |-> $past(scl_fall));
    p_ext_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_we |-> $past(scl_fall));
    p_pull_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pull) |-> !scl_lvl);
    p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RACK && scl_fall && q.nack && !sda_rise && !sda_fall) |=> (!q.pull && q.st == S_IDLE));
    p_read_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ADDR && scl_fall && q.bits == 4'd8 && q.sh[0] && rd_pending && !sda_rise && !sda_fall)
        |=> !q.pull);
    p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_fall && scl_lvl) |=> !q.pull);
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_rise && scl_lvl) |=> (!q.pull && q.st == S_IDLE));
endmodule

// File: rtl/pmon_i2c_slave.sv
module pmon_i2c_slave
    import pmon_i2c_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [1:0]        strap_hi,
    input  logic [1:0]        strap_lo,
    input  logic [6:0]        cmd_cur,
    input  logic              rd_pending,
    input  logic [CODE_W-1:0] volt_code,
    input  logic [CODE_W-1:0] curr_code,
    input  logic [7:0]        status_byte,
    output logic              cmd_we,
    output logic [6:0]        cmd_wdata,
    output logic              ext_we,
    output logic [1:0]        ext_sel,
    output logic [7:0]        ext_wdata
);
    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw, lvl, rise, fall;
    logic [6:0]         own_addr;
    logic [RBUF_W-1:0]  reply;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        pmon_i2c_filt #(
            .SYNC_STAGES(SYNC_STAGES),
            .DEPTH      (FILT_DEPTH)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw[g]),
            .level(lvl[g]),
            .rise (rise[g]),
            .fall (fall[g])
        );
    end

    pmon_i2c_reply u_reply (
        .strap_hi(strap_hi),
        .strap_lo(strap_lo),
        .cmd     (cmd_cur),
        .volt    (volt_code),
        .curr    (curr_code),
        .status  (status_byte),
        .own_addr(own_addr),
        .reply   (reply)
    );

    pmon_i2c_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (lvl[0]),
        .scl_rise  (rise[0]),
        .scl_fall  (fall[0]),
        .sda_lvl   (lvl[1]),
        .sda_rise  (rise[1]),
        .sda_fall  (fall[1]),
        .own_addr  (own_addr),
        .reply     (reply),
        .rd_pending(rd_pending),
        .sda_pull  (sda_pull),
        .cmd_we    (cmd_we),
        .cmd_wdata (cmd_wdata),
        .ext_we    (ext_we),
        .ext_sel   (ext_sel),
        .ext_wdata (ext_wdata)
    );
endmodule

// File: tb/pmon_i2c_slave_tb.sv
module pmon_i2c_slave_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, m_scl, m_sda, sda_line, sda_pull;
    logic [1:0]  strap_hi, strap_lo;
    logic [6:0]  cmd_cur;
    logic        rd_pending;
    logic [11:0] volt_code, curr_code;
    logic [7:0]  status_byte;
    logic        cmd_we, ext_we;
    logic [6:0]  cmd_wdata;
    logic [1:0]  ext_sel;
    logic [7:0]  ext_wdata;

    assign sda_line = m_sda & ~sda_pull;

    pmon_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_pull(sda_pull),
        .strap_hi(strap_hi), .strap_lo(strap_lo), .cmd_cur(cmd_cur), .rd_pending(rd_pending),
        .volt_code(volt_code), .curr_code(curr_code), .status_byte(status_byte),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .ext_we(ext_we), .ext_sel(ext_sel),
        .ext_wdata(ext_wdata)
    );

    int n_chk = 0, n_bad = 0;
    int cmd_cnt = 0, ext_cnt = 0;
    logic [6:0] cmd_last = '0;
    logic [1:0] esel_last = '0;
    logic [7:0] edat_last = '0;

    always @(negedge clk) begin
        if (rst_n && cmd_we) begin cmd_cnt <= cmd_cnt + 1; cmd_last <= cmd_wdata; end
        if (rst_n && ext_we) begin ext_cnt <= ext_cnt + 1; esel_last <= ext_sel; edat_last <= ext_wdata; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    // gbit selects the bit that carries an SDA low pulse of glen clocks (glen 0 = none)
    task automatic send_byte(input logic [7:0] b, output bit ack, input int gbit = -1, input int glen = 0);
        for (int i = 0; i < 8; i++) begin
            m_sda = b[7-i]; wq(Q); m_scl = 1'b1;
            if (i == gbit && glen > 0) begin
                wq(4); m_sda = 1'b0; wq(glen); m_sda = b[7-i]; wq(2*Q - 4 - glen);
            end else begin
                wq(2*Q);
            end
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = (sda_line == 1'b0);
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit do_ack);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
            b = {b[6:0], sda_line};
            wq(Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = do_ack ? 1'b0 : 1'b1; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        m_sda = 1'b1;
    endtask

    function automatic logic [23:0] exp_reply(input logic [6:0] c, input logic [11:0] v,
                                              input logic [11:0] i, input logic [7:0] s);
        bit von = c[0] | c[1];
        bit ion = c[2] | c[3];
        if (c[6]) return 24'(s) << 16;
        if (von && ion) return 24'((int'(v) / 16) * 65536 + (int'(i) / 16) * 256 + (int'(v) % 16) * 16 + int'(i) % 16);
        if (von) return 24'((int'(v) / 16) * 65536 + (int'(v) % 16) * 4096);
        if (ion) return 24'((int'(i) / 16) * 65536 + (int'(i) % 16) * 4096);
        return 24'h0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] got;
        int c0, e0;
        m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
        strap_hi = 2'd0; strap_lo = 2'd0; cmd_cur = '0; rd_pending = 1'b0;
        volt_code = '0; curr_code = '0; status_byte = '0;
        wq(5); rst_n = 1'b1; wq(10);

        // reset state (R8: line released, no strobes)
        chk(sda_pull == 1'b0, "R8 reset sda_pull", int'(sda_pull), 0);
        chk(cmd_we == 1'b0 && ext_we == 1'b0, "R2 reset strobes", int'({cmd_we, ext_we}), 0);

        // R1 and R4: full strap sweep with quick commands
        c0 = cmd_cnt; e0 = ext_cnt;
        for (int h = 0; h < 4; h++) begin
            for (int l = 0; l < 4; l++) begin
                strap_hi = 2'(h); strap_lo = 2'(l); wq(2);
                for (int a = 0; a < 16; a++) begin
                    bus_start; send_byte(8'(8'h60 + 2*a), ack); bus_stop;
                    chk(ack == (a == 4*h + l), "R1 address decode", int'(ack), int'(a == 4*h + l));
                end
            end
        end
        wq(4);
        chk(cmd_cnt == c0 && ext_cnt == e0, "R4 quick command strobes", cmd_cnt + ext_cnt - c0 - e0, 0);

        strap_hi = 2'd2; strap_lo = 2'd1; wq(2);   // address byte 0x72 / 0x73
        bus_start; send_byte(8'h52, ack); bus_stop;
        chk(!ack, "R1 foreign address", int'(ack), 0);

        // R2: command writes
        for (int k = 0; k < 8; k++) begin
            logic [6:0] v = 7'((k * 37 + 3) % 128);
            c0 = cmd_cnt;
            bus_start; send_byte(8'h72, ack); send_byte({1'b0, v}, ack); bus_stop; wq(2);
            chk(ack && cmd_cnt == c0 + 1, "R2 command strobe count", cmd_cnt - c0, 1);
            chk(cmd_last == v, "R2 command data", int'(cmd_last), int'(v));
        end

        // R3: extended writes for all selectors
        for (int s = 0; s < 4; s++) begin
            logic [7:0] dv = 8'(8'hC3 ^ (s * 53));
            e0 = ext_cnt; c0 = cmd_cnt;
            bus_start; send_byte(8'h72, ack); send_byte(8'(8'h80 + s), ack); send_byte(dv, ack); bus_stop; wq(2);
            chk(ext_cnt == e0 + ((s != 3) ? 1 : 0), "R3 ext strobe count", ext_cnt - e0, (s != 3) ? 1 : 0);
            chk(cmd_cnt == c0, "R3 no command strobe", cmd_cnt - c0, 0);
            if (s != 3) chk(esel_last == 2'(s) && edat_last == dv, "R3 ext sel/data",
                            int'({esel_last, edat_last}), int'({2'(s), dv}));
        end
        c0 = cmd_cnt; e0 = ext_cnt;
        bus_start; send_byte(8'h72, ack); send_byte(8'h15, ack); send_byte(8'h2B, ack);
        send_byte(8'h81, ack); bus_stop; wq(2);
        chk(ack && cmd_cnt == c0 + 1 && ext_cnt == e0 && cmd_last == 7'h15, "R3 extra bytes ignored",
            int'(cmd_last), 'h15);

        // R5, R6, R7: reply layouts over all low channel patterns plus status select
        for (int c = 0; c < 18; c++) begin
            logic [6:0] cv = (c < 16) ? 7'(c) : ((c == 16) ? 7'h40 : 7'h4F);
            logic [23:0] ex;
            int nb;
            string tag;
            cmd_cur = cv;
            volt_code = 12'(12'h3C9 ^ (c * 273));
            curr_code = 12'(12'hB72 ^ (c * 243));
            status_byte = 8'(8'h5A + c);
            ex = exp_reply(cv, volt_code, curr_code, status_byte);
            nb = cv[6] ? 1 : (((cv[0] | cv[1]) && (cv[2] | cv[3])) ? 3 : 2);
            tag = cv[6] ? "R7 status read" : ((nb == 3) ? "R5 both channels" : "R6 single channel");
            bus_start; send_byte(8'h73, ack);
            chk(ack, tag, int'(ack), 1);
            for (int b = 0; b < nb; b++) begin
                recv_byte(got, b != nb - 1);
                chk(got == ex[23 - 8*b -: 8], tag, int'(got), int'(ex[23 - 8*b -: 8]));
            end
            bus_stop;
        end

        // R8: after a NACK the slave keeps SDA released
        cmd_cur = 7'h05; volt_code = 12'h000; curr_code = 12'h000;
        begin
            int lows = 0;
            bus_start; send_byte(8'h73, ack);
            for (int b = 0; b < 3; b++) recv_byte(got, b != 2);
            for (int i = 0; i < 8; i++) begin
                m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
                if (sda_line == 1'b0) lows++;
                wq(Q); m_scl = 1'b0; wq(Q);
            end
            bus_stop;
            chk(lows == 0, "R8 released after nack", lows, 0);
        end

        // R9: read refused while a one-shot result is pending, write still accepted
        rd_pending = 1'b1;
        bus_start; send_byte(8'h73, ack); bus_stop;
        chk(!ack, "R9 read refused", int'(ack), 0);
        c0 = cmd_cnt;
        bus_start; send_byte(8'h72, ack); send_byte(8'h0A, ack); bus_stop; wq(2);
        chk(cmd_cnt == c0 + 1 && cmd_last == 7'h0A, "R9 write while pending", int'(cmd_last), 'h0A);
        rd_pending = 1'b0;
        cmd_cur = 7'h40; status_byte = 8'hE1;
        bus_start; send_byte(8'h73, ack);
        chk(ack, "R9 read accepted after pending", int'(ack), 1);
        recv_byte(got, 1'b0); bus_stop;
        chk(got == 8'hE1, "R9 status after pending", int'(got), 'hE1);

        // R10: stop and repeated start inside a data byte
        c0 = cmd_cnt;
        bus_start; send_byte(8'h72, ack);
        for (int i = 0; i < 4; i++) begin
            m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        end
        bus_stop; wq(2);
        chk(cmd_cnt == c0 && sda_pull == 1'b0, "R10 stop aborts", cmd_cnt - c0, 0);
        bus_start; send_byte(8'h72, ack);
        for (int i = 0; i < 4; i++) begin
            m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        end
        bus_start; send_byte(8'h72, ack); send_byte(8'h2A, ack); bus_stop; wq(2);
        chk(cmd_cnt == c0 + 1 && cmd_last == 7'h2A, "R10 restart aborts", int'(cmd_last), 'h2A);

        // R11: short SDA pulse ignored, long pulse seen as start and stop
        c0 = cmd_cnt;
        bus_start; send_byte(8'h72, ack); send_byte(8'h7F, ack, 1, 2); bus_stop; wq(2);
        chk(ack && cmd_cnt == c0 + 1 && cmd_last == 7'h7F, "R11 two-clock glitch ignored",
            int'(cmd_last), 'h7F);
        c0 = cmd_cnt;
        bus_start; send_byte(8'h72, ack); send_byte(8'h7F, ack, 1, 6); bus_stop; wq(2);
        chk(!ack && cmd_cnt == c0, "R11 six-clock pulse aborts", cmd_cnt - c0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule